// File: doc/BRIEF.md
# Countdown Watchdog Timer with Register Interface

This block is a watchdog timer that software controls through two 16-bit registers on a simple register bus. A count register holds the remaining time in units of 128 ms. A control register holds a word whose lowest bit lets the countdown run. Software arms the timer in two steps. It first writes a reload value, which is the timeout in milliseconds divided by 128. It then writes the start word 0x0085 to the control register.

To keep the timer from firing, software writes the reload value to the count register again before the count runs out. To stop the timer, software reads the control word, masks it with 0xFE, and writes the result back.

A prescaler divides the system clock down to one tick per 128 ms unit. While the enable bit is set, each tick lowers the count by one. When the count reaches zero, a sticky expiry flag drives the timeout output. The system can route that output to a non-maskable interrupt or to a reset request. The reset value of the count is 234 units, which is a 30 s timeout. Software keeps its own timeouts within 30 to 600 s, which is 234 to 4687 units.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the count register reads 234, the control register reads 0x0000 and the timeout output is low.
- R2: A write to byte offset 0x70 loads the count register with the written data. The write clears the timeout output on the next cycle. The new value reads back from offset 0x70 on the next cycle.
- R3: A write to byte offset 0x72 stores all 16 data bits in the control register, and they read back unchanged from offset 0x72. Bit 0 of the control register is the enable bit, so writing 0x0085 starts the countdown.
- R4: While bit 0 is set, the count drops by exactly one every TICK cycles, where TICK = CLK_FREQ_HZ * 128 / 1000. The first drop comes TICK cycles after the edge that set bit 0.
- R5: On the tick that takes the count from 1 to 0, the timeout output rises. The timeout output then stays high, and the count stays at 0, even if bit 0 is later cleared. Only a count write or reset clears the timeout output.
- R6: While bit 0 is clear, the count holds its value and the timeout output does not rise. Writing the masked stop word 0x0084 stops the countdown and keeps the other control bits as written.
- R7: A reload value of 0 written while the timer runs makes the timeout output rise at the next tick, TICK cycles after the write.
- R8: Reads from any offset other than 0x70 and 0x72 return 0. Writes to other offsets change neither register.
- R9: A count write while the timer runs restarts the tick phase. The next drop comes a full TICK cycles after that write, however much of the previous unit had elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the offset on bus_addr_i, combinational |
| expired_o | output | 1 | Sticky timeout indication |

## Verification
The assertions assume that a write lasts one cycle and that reset is held for at least one clock edge before traffic starts. The stimulus always drives a write strobe for a single edge and changes inputs only between edges. The assertions also assume that the tick period is at least two clocks. The bench sets the clock frequency parameter so that one unit lasts 32 cycles, which keeps every countdown short while preserving that spacing. Directed sequences cover enable, masked stop, reload during a partial unit, a zero reload and writes to other offsets.

// File: rtl/twd_pkg.sv
package twd_pkg;

    localparam int unsigned WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    // Byte offsets seen by software; the driver sequence depends on them.
    localparam logic [7:0] OFF_COUNT = 8'h70;
    localparam logic [7:0] OFF_CTRL  = 8'h72;

    // Position of the run bit in the control word.
    localparam int unsigned RUN_BIT = 0;

endpackage

// File: rtl/twd_prescaler.sv
module twd_prescaler #(
    parameter longint unsigned TICK_CYCLES = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.phase == LAST);
        tick_o  = run_i && at_last && !restart_i;
        if (restart_i || !run_i) begin
            st_d.phase = '0;
        end else if (at_last) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + PW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/twd_counter.sv
module twd_counter
    import twd_pkg::*;
#(
    parameter word_t RESET_COUNT = 16'd234
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  load_i,
    input  word_t load_val_i,
    input  logic  tick_i,
    output word_t count_o,
    output logic  expired_o
);
    typedef struct packed {
        word_t count;
        logic  expired;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.count   = load_val_i;
            st_d.expired = 1'b0;
        end else if (tick_i) begin
            if (st_q.count <= word_t'(1)) begin
                st_d.count   = '0;
                st_d.expired = 1'b1;
            end else begin
                st_d.count = st_q.count - word_t'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.count   <= RESET_COUNT;
            st_q.expired <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.count;
    assign expired_o = st_q.expired;

endmodule

// File: rtl/twd_regs.sv
module twd_regs
    import twd_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  word_t             wdata_i,
    input  word_t             count_i,
    output word_t             ctrl_o,
    output logic              load_o,
    output word_t             rdata_o
);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);

    typedef struct packed {
        word_t ctrl;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic hit_count, hit_ctrl;

    always_comb begin
        st_d      = st_q;
        hit_count = (addr_i == A_COUNT);
        hit_ctrl  = (addr_i == A_CTRL);
        load_o    = wr_i && hit_count;
        if (wr_i && hit_ctrl) begin
            st_d.ctrl = wdata_i;
        end
        if (hit_count) begin
            rdata_o = count_i;
        end else if (hit_ctrl) begin
            rdata_o = st_q.ctrl;
        end else begin
            rdata_o = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import twd_pkg::*;
#(
    parameter longint unsigned CLK_FREQ_HZ       = 100_000_000,
    parameter int unsigned     UNIT_MS           = 128,
    parameter int unsigned     DEFAULT_TIMEOUT_S = 30,
    parameter int unsigned     ADDR_W            = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [15:0]       bus_wdata_i,
    output logic [15:0]       bus_rdata_o,
    output logic              expired_o
);
    localparam longint unsigned TICK_CYCLES   = (CLK_FREQ_HZ * UNIT_MS) / 1000;
    localparam word_t           DEFAULT_COUNT = word_t'((DEFAULT_TIMEOUT_S * 1000) / UNIT_MS);

    word_t count_w;
    word_t ctrl_w;
    logic  load_w;
    logic  tick_w;
    logic  run_w;

    assign run_w = ctrl_w[RUN_BIT];

    twd_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .count_i (count_w),
        .ctrl_o  (ctrl_w),
        .load_o  (load_w),
        .rdata_o (bus_rdata_o)
    );

    twd_prescaler #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run_w),
        .restart_i (load_w),
        .tick_o    (tick_w)
    );

    twd_counter #(
        .RESET_COUNT (DEFAULT_COUNT)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load_w),
        .load_val_i (bus_wdata_i),
        .tick_i     (tick_w),
        .count_o    (count_w),
        .expired_o  (expired_o)
    );

endmodule

// File: rtl/twd_checker.sv
module twd_checker #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [15:0]       bus_wdata_i,
    input logic              expired_o,
    input logic [15:0]       count_w,
    input logic [15:0]       ctrl_w,
    input logic              tick_w
);
    logic wr_cnt, wr_ctl;
    assign wr_cnt = bus_wr_i && (bus_addr_i == ADDR_W'(8'h70));
    assign wr_ctl = bus_wr_i && (bus_addr_i == ADDR_W'(8'h72));

    p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_cnt |=> (count_w == $past(bus_wdata_i)) && !expired_o);

    p_ctrl_store_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ctl |=> ctrl_w == $past(bus_wdata_i));

    p_tick_needs_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_w |-> ctrl_w[0]);

    p_step_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_w && !wr_cnt && count_w > 16'd1) |=> count_w == $past(count_w) - 16'd1);

    p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expired_o && !wr_cnt) |=> expired_o && (count_w == 16'd0));

    p_rise_at_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(expired_o) |-> count_w == 16'd0);

    p_hold_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl_w[0] && !wr_cnt) |=> $stable(count_w) && ($past(expired_o) || !expired_o));

endmodule

bind tick_watchdog twd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .expired_o   (expired_o),
    .count_w     (count_w),
    .ctrl_w      (ctrl_w),
    .tick_w      (tick_w)
);

// File: tb/tick_watchdog_tb_top.sv
module tick_watchdog_tb_top;
    localparam int T = 32;   // 250 Hz * 128 ms / 1000

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        expired;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference state
    int m_cnt = 234, m_ctrl = 0, m_phase = 0;
    bit m_exp = 1'b0;

    always #5 clk = ~clk;

    tick_watchdog #(.CLK_FREQ_HZ(250)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .expired_o   (expired)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, updated on every edge from the inputs before it
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 234; m_ctrl = 0; m_phase = 0; m_exp = 1'b0;
        end else begin
            bit run, tk, ld;
            run = m_ctrl[0];
            ld  = wr && addr == 8'h70;
            tk  = run && !ld && (m_phase == T - 1);
            if (ld) begin
                m_cnt = wdata; m_exp = 1'b0;
            end else if (tk) begin
                if (m_cnt <= 1) begin m_cnt = 0; m_exp = 1'b1; end
                else m_cnt = m_cnt - 1;
            end
            if (ld || !run) m_phase = 0;
            else m_phase = (m_phase == T - 1) ? 0 : m_phase + 1;
            if (wr && addr == 8'h72) m_ctrl = wdata;
        end
    end

    // per-cycle comparison against the model (R4, R5, R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_rd;
            exp_rd = (addr == 8'h70) ? m_cnt : (addr == 8'h72) ? m_ctrl : 0;
            chk("R5 model expired", int'(expired), int'(m_exp));
            chk("R4 model rdata", int'(rdata), exp_rd);
        end
    end

    task automatic write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input int exp);
        addr = a; #1;
        chk(req, int'(rdata), exp);
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        read_chk("R1 count reset", 8'h70, 234);
        read_chk("R1 ctrl reset", 8'h72, 0);
        chk("R1 expired reset", int'(expired), 0);

        // R2 load while stopped, R6 hold
        write(8'h70, 16'd10);
        read_chk("R2 count load", 8'h70, 10);
        wait_edges(100);
        read_chk("R6 hold while stopped", 8'h70, 10);
        chk("R6 no expiry while stopped", int'(expired), 0);

        // R3 start word, R4 cadence
        write(8'h72, 16'h0085);
        read_chk("R3 ctrl readback", 8'h72, 16'h0085);
        addr = 8'h70;
        wait_edges(3 * T - 1);
        read_chk("R4 before third drop", 8'h70, 8);
        wait_edges(1);
        read_chk("R4 third drop", 8'h70, 7);

        // R6 masked stop word
        write(8'h72, 16'h0084);
        read_chk("R6 stop keeps other bits", 8'h72, 16'h0084);
        wait_edges(2 * T);
        read_chk("R6 count frozen", 8'h70, 7);

        // R5 expiry
        write(8'h70, 16'd2);
        write(8'h72, 16'h0085);
        addr = 8'h70;
        wait_edges(2 * T - 1);
        read_chk("R5 before zero", 8'h70, 1);
        chk("R5 not yet expired", int'(expired), 0);
        wait_edges(1);
        read_chk("R5 reaches zero", 8'h70, 0);
        chk("R5 expired rises", int'(expired), 1);
        wait_edges(3 * T);
        chk("R5 sticky running", int'(expired), 1);
        read_chk("R5 count stays zero", 8'h70, 0);
        write(8'h72, 16'h0084);
        wait_edges(5);
        chk("R5 sticky after stop", int'(expired), 1);
        write(8'h70, 16'd5);
        chk("R2 count write clears expiry", int'(expired), 0);

        // R7 zero reload while running
        write(8'h72, 16'h0085);
        wait_edges(T / 2);
        write(8'h70, 16'd0);
        wait_edges(T - 1);
        chk("R7 no expiry before tick", int'(expired), 0);
        wait_edges(1);
        chk("R7 expiry at next tick", int'(expired), 1);

        // R9 reload restarts phase
        write(8'h70, 16'd20);
        wait_edges(T / 2);
        write(8'h70, 16'd20);
        addr = 8'h70;
        wait_edges(T - 1);
        read_chk("R9 full unit after reload", 8'h70, 20);
        wait_edges(1);
        read_chk("R9 drop after full unit", 8'h70, 19);

        // R8 other offsets
        write(8'h72, 16'h0084);
        write(8'h74, 16'hFFFF);
        write(8'h71, 16'h1234);
        read_chk("R8 other offset reads zero", 8'h74, 0);
        read_chk("R8 count untouched", 8'h70, 19);
        read_chk("R8 ctrl untouched", 8'h72, 16'h0084);

        wait_edges(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule